// File: doc/BRIEF.md
# Parallel Host Port with Ready/Request Handshake

This block is the slave side of an 8-bit parallel host port that uses an active-low enable strobe, an active-low data strobe and a read/write direction line. Every input is registered once on the block clock. A bus access is active only while both sampled strobes are low. It takes effect when either strobe returns high, and only if it was held long enough and followed a long enough idle gap. An address bit selects the command register or the data channel. Command bytes go to the core on a one-cycle strobe. Some opcodes also move the channel into a read or a write direction, and those opcodes empty the buffer.

Data passes through an internal first-in first-out buffer. In the read direction the core fills the buffer and the host drains it. In the write direction the host fills it and the core drains it. The request output tells the host when it may proceed, and its meaning follows the direction. In the read direction a low level means a byte is waiting. In the write direction a high level means there is room. Accesses that cannot complete are dropped, and each one sets an error flag that stays set until reset.

Top module: `hostport_req`

## Requirements
- R1: An access is active only while both sampled strobes (`hp_en_n`, `hp_ds_n`) are low. It takes effect on the first sampled cycle in which either strobe is high. A cycle with only one strobe low has no effect.
- R2: The direction and address are captured on the first active sampled cycle. `hp_rw`=1 means read and 0 means write. `hp_addr`=1 selects the command register and 0 selects the data channel. Write data is taken from the last active sampled cycle.
- R3: An access held active for fewer than MIN_WIDTH sampled cycles is ignored.
- R4: An access that begins after fewer than MIN_RECOV inactive sampled cycles is ignored.
- R5: A command write puts its byte on `cmd_code`, with `cmd_stb` high for one cycle, on the cycle after the access takes effect. Opcodes OP_IDENT, OP_XLAT_RD, OP_PKT_RD and OP_COUNT select the read direction. OP_XLAT_WR and OP_PKT_WR select the write direction. Any other byte leaves the direction unchanged. Reset selects the read direction.
- R6: Each of the six direction opcodes empties the buffer. Other command bytes do not.
- R7: In the read direction, `hp_req` is a registered output that is low when the buffer held data on the previous cycle and high when it was empty.
- R8: In the write direction, `hp_req` is high only when the buffer was not full and the sampled `hp_rw` was low. A rise of `hp_rw` drives `hp_req` low within 2 cycles.
- R9: The buffer holds DEPTH bytes in order. A host data write or a `core_pop` moves data only in the write direction. A `core_push` or a host data read moves data only in the read direction. `buf_empty`, `buf_full` and `core_rdata` (the oldest byte) reflect the buffer.
- R10: A host data write to a full buffer or in the read direction, or a host data read of an empty buffer or in the write direction, is dropped and sets `err_flag`. `err_flag` stays high until reset.
- R11: `hp_doe` is high exactly while both sampled strobes are low and the sampled `hp_rw` is high. `hp_dout` then shows the last command byte when the sampled address is 1, and the oldest buffered byte when it is 0.
- R12: After reset: `hp_req`=1, `buf_empty`=1, `err_flag`=0, `hp_doe`=0, `cmd_stb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_en_n | input | 1 | Enable strobe, active low |
| hp_ds_n | input | 1 | Data strobe, active low |
| hp_rw | input | 1 | Direction: 1 read, 0 write |
| hp_addr | input | 1 | 1 command register, 0 data channel |
| hp_din | input | DW | Host write data |
| hp_dout | output | DW | Host read data |
| hp_doe | output | 1 | Read data output enable |
| hp_req | output | 1 | Request/ready handshake to host |
| core_push | input | 1 | Core writes a byte for the host (read direction) |
| core_wdata | input | DW | Core byte to push |
| core_pop | input | 1 | Core takes a host byte (write direction) |
| core_rdata | output | DW | Oldest buffered byte |
| buf_empty | output | 1 | Buffer empty |
| buf_full | output | 1 | Buffer full |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | DW | Last command byte delivered |
| err_flag | output | 1 | Sticky dropped-access flag |

## Verification
The bench builds the block with DEPTH=8, MIN_WIDTH=2 and MIN_RECOV=3. With these values a one-cycle strobe pulse falls under the width limit. A one-cycle idle gap breaks the recovery rule. Filling the buffer to its limit takes only eight host writes. The reference model follows strobe sampling, direction changes, buffer flushes and the request level on every cycle. Directed sequences check ordering around the ignored accesses, the overflow drop and the response of the request output to the direction line.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } hp_mode_e;

  // direction and target captured at the start of a host access
  typedef struct packed {
    logic rw;      // 1: read
    logic is_cmd;  // 1: command register
  } hp_acc_t;

endpackage

// File: rtl/hp_strobe.sv
module hp_strobe
  import hp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MIN_WIDTH = 3,
  parameter int MIN_RECOV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          ds_n,
  input  logic          rw,
  input  logic          addr,
  input  logic [DW-1:0] din,
  output logic          act,
  output logic          s_rw,
  output logic          s_addr,
  output logic          commit,
  output hp_acc_t       acc,
  output logic [DW-1:0] wdata
);

  localparam int WCW = (MIN_WIDTH < 1) ? 1 : $clog2(MIN_WIDTH + 1);
  localparam int RCW = (MIN_RECOV < 1) ? 1 : $clog2(MIN_RECOV + 1);
  localparam logic [WCW-1:0] WMAX = WCW'(MIN_WIDTH);
  localparam logic [RCW-1:0] RMAX = RCW'(MIN_RECOV);

  logic          en_q, ds_q, rw_q, addr_q;
  logic [DW-1:0] din_q;
  logic          act_d;
  hp_acc_t       acc_q, acc_n;
  logic          ok_q, ok_n;
  logic [WCW-1:0] wid_q, wid_n;
  logic [RCW-1:0] idle_q, idle_n;
  logic [DW-1:0] wd_q, wd_n;
  logic          start;

  assign act    = !en_q && !ds_q;
  assign start  = act && !act_d;
  assign s_rw   = rw_q;
  assign s_addr = addr_q;
  assign acc    = acc_q;
  assign wdata  = wd_q;
  assign commit = !act && act_d && ok_q && (wid_q >= WMAX);

  always_comb begin
    acc_n  = acc_q;
    ok_n   = ok_q;
    wid_n  = wid_q;
    wd_n   = wd_q;
    if (start) begin
      acc_n.rw     = rw_q;
      acc_n.is_cmd = addr_q;
      ok_n         = (idle_q >= RMAX);
      wid_n        = WCW'(1);
    end else if (act && (wid_q < WMAX)) begin
      wid_n = wid_q + WCW'(1);
    end
    if (act) wd_n = din_q;
    if (act)                 idle_n = '0;
    else if (idle_q < RMAX)  idle_n = idle_q + RCW'(1);
    else                     idle_n = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      ds_q   <= 1'b1;
      rw_q   <= 1'b0;
      addr_q <= 1'b0;
      din_q  <= '0;
      act_d  <= 1'b0;
      acc_q  <= '0;
      ok_q   <= 1'b0;
      wid_q  <= '0;
      idle_q <= RMAX;
      wd_q   <= '0;
    end else begin
      en_q   <= en_n;
      ds_q   <= ds_n;
      rw_q   <= rw;
      addr_q <= addr;
      din_q  <= din;
      act_d  <= act;
      acc_q  <= acc_n;
      ok_q   <= ok_n;
      wid_q  <= wid_n;
      idle_q <= idle_n;
      wd_q   <= wd_n;
    end
  end

endmodule

// File: rtl/hp_cmd.sv
module hp_cmd
  import hp_pkg::*;
#(
  parameter int          DW         = 8,
  parameter logic [DW-1:0] OP_IDENT   = 'h01,
  parameter logic [DW-1:0] OP_XLAT_RD = 'h02,
  parameter logic [DW-1:0] OP_PKT_RD  = 'h03,
  parameter logic [DW-1:0] OP_COUNT   = 'h04,
  parameter logic [DW-1:0] OP_XLAT_WR = 'h82,
  parameter logic [DW-1:0] OP_PKT_WR  = 'h83
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] code,
  output hp_mode_e      mode,
  output logic          flush,
  output logic [DW-1:0] last,
  output logic          stb,
  output logic [DW-1:0] stb_code
);

  hp_mode_e      mode_q, mode_n;
  logic [DW-1:0] last_q, last_n;
  logic          stb_q;
  logic [DW-1:0] sc_q, sc_n;
  logic          to_rd, to_wr;

  assign to_rd = (code == OP_IDENT) || (code == OP_XLAT_RD) ||
                 (code == OP_PKT_RD) || (code == OP_COUNT);
  assign to_wr = (code == OP_XLAT_WR) || (code == OP_PKT_WR);
  assign flush = we && (to_rd || to_wr);

  always_comb begin
    mode_n = mode_q;
    if (we && to_rd)      mode_n = MODE_RD;
    else if (we && to_wr) mode_n = MODE_WR;
    last_n = we ? code : last_q;
    sc_n   = we ? code : sc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RD;
      last_q <= '0;
      stb_q  <= 1'b0;
      sc_q   <= '0;
    end else begin
      mode_q <= mode_n;
      last_q <= last_n;
      stb_q  <= we;
      sc_q   <= sc_n;
    end
  end

  assign mode     = mode_q;
  assign last     = last_q;
  assign stb      = stb_q;
  assign stb_code = sc_q;

endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign do_push = push && !flush;
  assign do_pop  = pop && !flush;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = (wp_q == LAST) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_n = (rp_q == LAST) ? '0 : rp_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + CW'(1);
        2'b01:   cnt_n = cnt_q - CW'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (do_push && (wp_q == AW'(i))) mem[i] <= wdata;
    end
  end

  assign head  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;

endmodule

// File: rtl/hostport_req.sv
module hostport_req
  import hp_pkg::*;
#(
  parameter int            DW         = 8,
  parameter int            DEPTH      = 8,
  parameter int            MIN_WIDTH  = 3,
  parameter int            MIN_RECOV  = 2,
  parameter logic [DW-1:0] OP_IDENT   = 'h01,
  parameter logic [DW-1:0] OP_XLAT_RD = 'h02,
  parameter logic [DW-1:0] OP_PKT_RD  = 'h03,
  parameter logic [DW-1:0] OP_COUNT   = 'h04,
  parameter logic [DW-1:0] OP_XLAT_WR = 'h82,
  parameter logic [DW-1:0] OP_PKT_WR  = 'h83
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hp_en_n,
  input  logic          hp_ds_n,
  input  logic          hp_rw,
  input  logic          hp_addr,
  input  logic [DW-1:0] hp_din,
  output logic [DW-1:0] hp_dout,
  output logic          hp_doe,
  output logic          hp_req,
  input  logic          core_push,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_pop,
  output logic [DW-1:0] core_rdata,
  output logic          buf_empty,
  output logic          buf_full,
  output logic          cmd_stb,
  output logic [DW-1:0] cmd_code,
  output logic          err_flag
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          act, s_rw, s_addr, commit;
  hp_acc_t       acc;
  logic [DW-1:0] wdata;
  hp_mode_e      mode;
  logic          flush, cmd_we;
  logic [DW-1:0] last_cmd;
  logic          push, pop, empty, full;
  logic [DW-1:0] head, push_data;
  logic [CW-1:0] fill_cnt;
  logic          host_wr, host_rd, err_set;
  logic          mode_is_wr;
  logic          req_q, req_n;
  logic          err_q, err_n;

  hp_strobe #(
    .DW(DW), .MIN_WIDTH(MIN_WIDTH), .MIN_RECOV(MIN_RECOV)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .en_n(hp_en_n), .ds_n(hp_ds_n),
    .rw(hp_rw), .addr(hp_addr), .din(hp_din),
    .act(act), .s_rw(s_rw), .s_addr(s_addr), .commit(commit),
    .acc(acc), .wdata(wdata)
  );

  assign cmd_we  = commit && acc.is_cmd && !acc.rw;
  assign host_wr = commit && !acc.is_cmd && !acc.rw;
  assign host_rd = commit && !acc.is_cmd && acc.rw;

  hp_cmd #(
    .DW(DW), .OP_IDENT(OP_IDENT), .OP_XLAT_RD(OP_XLAT_RD),
    .OP_PKT_RD(OP_PKT_RD), .OP_COUNT(OP_COUNT),
    .OP_XLAT_WR(OP_XLAT_WR), .OP_PKT_WR(OP_PKT_WR)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .code(wdata),
    .mode(mode), .flush(flush), .last(last_cmd),
    .stb(cmd_stb), .stb_code(cmd_code)
  );

  assign mode_is_wr = (mode == MODE_WR);

  // buffer flow control: each direction has one producer and one consumer
  always_comb begin
    push      = 1'b0;
    pop       = 1'b0;
    push_data = wdata;
    err_set   = 1'b0;
    if (mode_is_wr) begin
      if (host_wr && !full) push = 1'b1;
      if (core_pop && !empty) pop = 1'b1;
      err_set = (host_wr && full) || host_rd;
    end else begin
      if (core_push && !full) begin
        push      = 1'b1;
        push_data = core_wdata;
      end
      if (host_rd && !empty) pop = 1'b1;
      err_set = (host_rd && empty) || host_wr;
    end
  end

  hp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .wdata(push_data), .head(head), .empty(empty), .full(full),
    .count(fill_cnt)
  );

  always_comb begin
    req_n = mode_is_wr ? (!full && !s_rw) : empty;
    err_n = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b1;
      err_q <= 1'b0;
    end else begin
      req_q <= req_n;
      err_q <= err_n;
    end
  end

  assign hp_req     = req_q;
  assign err_flag   = err_q;
  assign hp_doe     = act && s_rw;
  assign hp_dout    = s_addr ? last_cmd : head;
  assign core_rdata = head;
  assign buf_empty  = empty;
  assign buf_full   = full;

endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hp_en_n,
  input logic                       hp_ds_n,
  input logic                       hp_rw,
  input logic                       hp_doe,
  input logic                       hp_req,
  input logic                       buf_empty,
  input logic                       err_flag,
  input logic                       cmd_stb,
  input logic                       mode_wr,
  input logic [$clog2(DEPTH+1)-1:0] fill
);

  // R11
  doe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_doe |-> $past(!hp_en_n && !hp_ds_n && hp_rw));

  // R8
  wr_ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_wr) && $past(hp_rw, 2)) |-> !hp_req);

  // R7
  rd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mode_wr) |-> (hp_req == $past(buf_empty)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_flag) |-> err_flag);

  // R5
  mode_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr != $past(mode_wr)) |-> cmd_stb);

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill <= ($clog2(DEPTH+1))'(DEPTH)) && (buf_empty == (fill == '0)));

endmodule

bind hostport_req hp_chk #(.DEPTH(DEPTH)) u_hp_chk (
  .clk(clk), .rst_n(rst_n), .hp_en_n(hp_en_n), .hp_ds_n(hp_ds_n),
  .hp_rw(hp_rw), .hp_doe(hp_doe), .hp_req(hp_req), .buf_empty(buf_empty),
  .err_flag(err_flag), .cmd_stb(cmd_stb), .mode_wr(mode_is_wr),
  .fill(fill_cnt)
);

// File: tb/hostport_req_test.sv
module hostport_req_test;

  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int MW = 2;
  localparam int MR = 3;
  localparam logic [7:0] C_ID  = 8'h01;
  localparam logic [7:0] C_TRD = 8'h02;
  localparam logic [7:0] C_PRD = 8'h03;
  localparam logic [7:0] C_CNT = 8'h04;
  localparam logic [7:0] C_TWR = 8'h82;
  localparam logic [7:0] C_PWR = 8'h83;

  logic clk, rst_n;
  logic hp_en_n, hp_ds_n, hp_rw, hp_addr;
  logic [7:0] hp_din, hp_dout, core_wdata, core_rdata, cmd_code;
  logic hp_doe, hp_req, core_push, core_pop, buf_empty, buf_full, cmd_stb, err_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  hostport_req #(
    .DW(DW), .DEPTH(DEPTH), .MIN_WIDTH(MW), .MIN_RECOV(MR),
    .OP_IDENT(C_ID), .OP_XLAT_RD(C_TRD), .OP_PKT_RD(C_PRD),
    .OP_COUNT(C_CNT), .OP_XLAT_WR(C_TWR), .OP_PKT_WR(C_PWR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .hp_en_n(hp_en_n), .hp_ds_n(hp_ds_n),
    .hp_rw(hp_rw), .hp_addr(hp_addr), .hp_din(hp_din), .hp_dout(hp_dout),
    .hp_doe(hp_doe), .hp_req(hp_req), .core_push(core_push),
    .core_wdata(core_wdata), .core_pop(core_pop), .core_rdata(core_rdata),
    .buf_empty(buf_empty), .buf_full(buf_full), .cmd_stb(cmd_stb),
    .cmd_code(cmd_code), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_en, m_ds, m_rw, m_addr, m_actd, m_caprw, m_capaddr, m_okrec;
  bit m_mode, m_err, m_cmdstb, m_hreq;
  int m_wid, m_idle;
  logic [7:0] m_din, m_wdata, m_last, m_cmdcode;
  logic [7:0] q[$];

  function automatic bit is_rd_op(logic [7:0] c);
    return (c == C_ID) || (c == C_TRD) || (c == C_PRD) || (c == C_CNT);
  endfunction
  function automatic bit is_wr_op(logic [7:0] c);
    return (c == C_TWR) || (c == C_PWR);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 1; m_ds = 1; m_rw = 0; m_addr = 0; m_din = 0;
      m_actd = 0; m_caprw = 0; m_capaddr = 0; m_okrec = 0;
      m_wid = 0; m_idle = MR; m_wdata = 0; m_mode = 0; m_err = 0;
      m_last = 0; m_cmdstb = 0; m_cmdcode = 0; m_hreq = 1;
      q.delete();
    end else begin
      bit act, commit, full, empty, hnew, flush, oldmode;
      bit hpush, hpop, cpush, cpop;
      act = !m_en && !m_ds;
      commit = !act && m_actd && m_okrec && (m_wid >= MW);
      full = (q.size() == DEPTH);
      empty = (q.size() == 0);
      oldmode = m_mode;
      hnew = oldmode ? (!full && !m_rw) : empty;
      flush = 0; hpush = 0; hpop = 0; cpush = 0; cpop = 0;
      m_cmdstb = 0;
      if (commit && m_capaddr && !m_caprw) begin
        m_cmdstb = 1; m_cmdcode = m_wdata; m_last = m_wdata;
        if (is_rd_op(m_wdata)) begin m_mode = 0; flush = 1; end
        else if (is_wr_op(m_wdata)) begin m_mode = 1; flush = 1; end
      end
      if (commit && !m_capaddr) begin
        if (m_caprw) begin
          if (!oldmode && !empty) hpop = 1; else m_err = 1;
        end else begin
          if (oldmode && !full) hpush = 1; else m_err = 1;
        end
      end
      if (core_push && !oldmode && !full) cpush = 1;
      if (core_pop && oldmode && !empty) cpop = 1;
      if (flush) q.delete();
      else begin
        if (hpop || cpop) void'(q.pop_front());
        if (hpush) q.push_back(m_wdata);
        if (cpush) q.push_back(core_wdata);
      end
      if (act && !m_actd) begin
        m_capaddr = m_addr; m_caprw = m_rw; m_wid = 1; m_okrec = (m_idle >= MR);
      end else if (act && m_wid < MW) m_wid++;
      if (act) m_wdata = m_din;
      m_idle = act ? 0 : ((m_idle < MR) ? m_idle + 1 : m_idle);
      m_actd = act;
      m_en = hp_en_n; m_ds = hp_ds_n; m_rw = hp_rw; m_addr = hp_addr; m_din = hp_din;
      m_hreq = hnew;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit edoe;
      ck(m_mode ? "R8 hreq" : "R7 hreq", hp_req, m_hreq);
      ck("R10 err", err_flag, m_err);
      ck("R9 empty", buf_empty, q.size() == 0);
      ck("R9 full", buf_full, q.size() == DEPTH);
      ck("R5 stb", cmd_stb, m_cmdstb);
      if (m_cmdstb) ck("R5 code", cmd_code, m_cmdcode);
      edoe = !m_en && !m_ds && m_rw;
      ck("R11 doe", hp_doe, edoe);
      if (edoe && m_addr) ck("R11 dout", hp_dout, m_last);
      if (edoe && !m_addr && q.size() > 0) ck("R11 dout", hp_dout, q[0]);
      if (q.size() > 0) ck("R9 rdata", core_rdata, q[0]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic host(input bit rw, input bit a, input logic [7:0] d,
                      input int wid, input int gap, input bit use_ds,
                      output logic [7:0] rd);
    @(negedge clk);
    hp_rw = rw; hp_addr = a; hp_din = d; hp_en_n = 0; hp_ds_n = !use_ds;
    repeat (wid) @(negedge clk);
    rd = hp_dout;
    hp_en_n = 1; hp_ds_n = 1; hp_rw = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic cpush(input logic [7:0] d);
    @(negedge clk); core_push = 1; core_wdata = d;
    @(negedge clk); core_push = 0;
  endtask

  task automatic cpop(output logic [7:0] d);
    @(negedge clk); d = core_rdata; core_pop = 1;
    @(negedge clk); core_pop = 0;
  endtask

  task automatic summary;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] r;
    rst_n = 0; hp_en_n = 1; hp_ds_n = 1; hp_rw = 0; hp_addr = 0; hp_din = 0;
    core_push = 0; core_pop = 0; core_wdata = 0;
    repeat (4) @(negedge clk);
    ck("R12 req", hp_req, 1);
    ck("R12 empty", buf_empty, 1);
    ck("R12 err", err_flag, 0);
    ck("R12 doe", hp_doe, 0);
    ck("R12 stb", cmd_stb, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: one strobe only, would be a wrong-direction error if counted
    host(0, 0, 8'h11, 3, 4, 0, r);
    ck("R1 no access", err_flag, 0);

    // R7, R9: core fills in read direction
    cpush(8'hA1); cpush(8'hA2);
    repeat (2) @(negedge clk);
    ck("R7 data waiting", hp_req, 0);
    host(1, 0, 8'h00, 3, 4, 1, r);
    ck("R2 read first", r, 8'hA1);
    ck("R7 still waiting", hp_req, 0);
    host(1, 0, 8'h00, 3, 4, 1, r);
    ck("R11 read second", r, 8'hA2);
    ck("R7 drained", hp_req, 1);
    ck("R9 drained", buf_empty, 1);

    // R5, R6: write-direction opcode flushes a pending byte
    cpush(8'hA3);
    repeat (2) @(negedge clk);
    ck("R7 pending", hp_req, 0);
    host(0, 1, C_TWR, 3, 4, 1, r);
    ck("R6 flushed", buf_empty, 1);
    ck("R5 write dir", hp_req, 1);

    // R8: direction line high forces not-ready within 2 cycles
    @(negedge clk); hp_rw = 1;
    repeat (2) @(negedge clk);
    ck("R8 rw rise", hp_req, 0);
    hp_rw = 0;
    repeat (3) @(negedge clk);
    ck("R8 rw low", hp_req, 1);

    // R3, R4: short pulse and short recovery are ignored
    host(0, 0, 8'hB0, 2, 4, 1, r);
    host(0, 0, 8'hB1, 2, 4, 1, r);
    host(0, 0, 8'hB2, 1, 4, 1, r);
    host(0, 0, 8'hB3, 2, 0, 1, r);
    host(0, 0, 8'hB4, 2, 4, 1, r);
    host(0, 0, 8'hB5, 2, 4, 1, r);
    cpop(r); ck("R9 order", r, 8'hB0);
    cpop(r); ck("R9 order", r, 8'hB1);
    cpop(r); ck("R3 short skipped", r, 8'hB3);
    cpop(r); ck("R4 early skipped", r, 8'hB5);
    @(negedge clk);
    ck("R9 empty", buf_empty, 1);
    ck("R10 no error yet", err_flag, 0);

    // R5, R6: unknown byte keeps direction and contents
    host(0, 0, 8'hC0, 2, 4, 1, r);
    host(0, 1, 8'h55, 2, 4, 1, r);
    ck("R5 unknown keeps", hp_req, 1);
    ck("R6 unknown no flush", buf_empty, 0);

    // R5, R6: identify opcode goes to read direction and flushes
    host(0, 1, C_ID, 2, 4, 1, r);
    ck("R6 ident flush", buf_empty, 1);
    ck("R7 read dir empty", hp_req, 1);
    host(1, 1, 8'h00, 2, 4, 1, r);
    ck("R11 cmd readback", r, C_ID);
    ck("R11 cmd read no error", err_flag, 0);

    // R10: read of empty buffer
    host(1, 0, 8'h00, 2, 4, 1, r);
    ck("R10 empty read", err_flag, 1);

    // R10: overflow in write direction
    host(0, 1, C_PWR, 2, 4, 1, r);
    for (int i = 0; i < DEPTH; i++) host(0, 0, 8'hD0 + 8'(i), 2, 3, 1, r);
    @(negedge clk);
    ck("R8 full", hp_req, 0);
    ck("R9 full", buf_full, 1);
    host(0, 0, 8'hEE, 2, 4, 1, r);
    for (int i = 0; i < DEPTH; i++) begin
      cpop(r);
      ck("R10 overflow dropped", r, 8'hD0 + 8'(i));
    end
    @(negedge clk);
    ck("R10 sticky", err_flag, 1);
    ck("R9 final empty", buf_empty, 1);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule